// File: doc/BRIEF.md
# Buffered Output Compare Channel Pair

This block is one slice of a general timer. A counter runs from zero up to a programmable modulo value and advances only on cycles where the count enable is high. Two output-compare channels watch the count. Each channel has its own compare register and its own output pin.

A link bit joins the two channels into one buffered compare channel that drives the channel-0 pin. While the pair is linked, software prepares the next compare value in whichever register is not in use. The new value takes over only at the next counter overflow, so the output pattern never sees a half-updated threshold.

When the pair is linked, channel 1's pin is handed back for general-purpose use, and a release signal tells the surrounding logic so.

Top module: `bufcmp_pair`

## Requirements
- R1: On each cycle with `cntEn` high, the count advances by one. When the count equals the modulo value (address 0), the next enabled cycle wraps it to 0 and sets `ovfFlag`. With `cntEn` low, the count, the pins and the flags do not change.
- R2: The compare action is set by control-register bits [2:1]: 00 no change, 01 toggle, 10 drive low, 11 drive high. A match tick is an enabled cycle on which the count equals the controlling compare value. The action shows on `ch0Out` after the clock edge that ends that cycle.
- R3: Control bit 3 set makes `ch0Out` toggle on every overflow tick. If a match and an overflow fall on the same tick, this toggle is applied after the compare action.
- R4: `matchFlag` is set by a channel-0 match tick and `ovfFlag` by an overflow tick. Each flag stays set until a control write (address 3) carries a 1 in bit 4 (match flag) or bit 5 (overflow flag). A setting event in the same cycle wins over the clear.
- R5: Control bit 0 links the pair. At the moment of linking, the channel-0 compare register (address 1) controls `ch0Out`.
- R6: While channel 0 controls, a write to the channel-1 compare register (address 2) hands control to channel 1 at the next overflow tick, and not earlier.
- R7: At every overflow tick while linked, control passes to whichever compare register was written last. This includes a write in that same cycle.
- R8: A write to the compare register that is in control takes effect from the next cycle, like an unbuffered compare. It also cancels a switch that an earlier write to the other register had set up.
- R9: While linked, `ch1Release` is high and `ch1Out` is held low from the cycle after linking.
- R10: With bit 0 clear, the channels run independently. `ch0Out` follows the channel-0 register with the selected action, and `ch1Out` toggles on each match tick against the channel-1 register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 modulo, 1 compare 0, 2 compare 1, 3 control |
| wrData | input | CNT_W | Write data |
| cntEn | input | 1 | Counter clock enable |
| ch0Out | output | 1 | Channel-0 / buffered compare pin |
| ch1Out | output | 1 | Channel-1 compare pin |
| ch1Release | output | 1 | High when channel-1 pin is released |
| matchFlag | output | 1 | Sticky channel-0 compare flag |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The bench targets the point where a written channel-1 value must wait for the overflow tick. A design that switched at once would move the output edge into the current period. It also writes to both registers inside one period, and writes to the register in control after a switch has been set up. A design that remembered only the first write, or that failed to cancel the switch, would keep the wrong threshold for a whole period. It also places matches on the overflow tick with overflow toggling enabled, to expose a wrong order of the two effects. It also checks that flags survive clear writes that carry the other bit, and that channel 1's pin stays quiet while the pair is linked.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
  localparam logic [1:0] ADDR_MOD  = 2'd0;
  localparam logic [1:0] ADDR_CMP0 = 2'd1;
  localparam logic [1:0] ADDR_CMP1 = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  localparam int BIT_LINK   = 0;
  localparam int BIT_ACT_LO = 1;
  localparam int BIT_TOGOVF = 3;
  localparam int BIT_CLRM   = 4;
  localparam int BIT_CLRO   = 5;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmpAct_e;

  typedef struct packed {
    logic    linked;
    cmpAct_e act;
    logic    togOvf;
    logic    clrMatch;
    logic    clrOvf;
  } ctlStrobe_t;
endpackage

// File: rtl/bcp_ctrl.sv
module bcp_ctrl
  import bcp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             ovfTick,
  output ctlStrobe_t       ctl,
  output logic [CNT_W-1:0] modVal,
  output logic [CNT_W-1:0] activeCmp,
  output logic [CNT_W-1:0] cmp1Val
);
  logic [CNT_W-1:0] cmp0Val;
  logic linkQ, togQ, selQ, lastQ, lastNext, linkRise;
  cmpAct_e actQ;
  logic ctlWr, cmp0Wr, cmp1Wr;

  assign ctlWr    = wrEn && (wrAddr == ADDR_CTRL);
  assign cmp0Wr   = wrEn && (wrAddr == ADDR_CMP0);
  assign cmp1Wr   = wrEn && (wrAddr == ADDR_CMP1);
  assign linkRise = ctlWr && wrData[BIT_LINK] && !linkQ;

  // most recent writer of the pair, including a write this cycle
  always_comb begin
    lastNext = lastQ;
    if (cmp1Wr)      lastNext = 1'b1;
    else if (cmp0Wr) lastNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modVal  <= '1;
      cmp0Val <= '0;
      cmp1Val <= '0;
      linkQ   <= 1'b0;
      togQ    <= 1'b0;
      actQ    <= ACT_NONE;
      selQ    <= 1'b0;
      lastQ   <= 1'b0;
    end else begin
      if (wrEn && wrAddr == ADDR_MOD) modVal <= wrData;
      if (cmp0Wr) cmp0Val <= wrData;
      if (cmp1Wr) cmp1Val <= wrData;
      if (ctlWr) begin
        linkQ <= wrData[BIT_LINK];
        actQ  <= cmpAct_e'(wrData[BIT_ACT_LO+1:BIT_ACT_LO]);
        togQ  <= wrData[BIT_TOGOVF];
      end
      lastQ <= linkRise ? 1'b0 : lastNext;
      if (linkRise || !linkQ) selQ <= 1'b0;
      else if (ovfTick)       selQ <= lastNext;
    end
  end

  assign activeCmp = (linkQ && selQ) ? cmp1Val : cmp0Val;

  always_comb begin
    ctl.linked   = linkQ;
    ctl.act      = actQ;
    ctl.togOvf   = togQ;
    ctl.clrMatch = ctlWr && wrData[BIT_CLRM];
    ctl.clrOvf   = ctlWr && wrData[BIT_CLRO];
  end
endmodule

// File: rtl/bcp_datapath.sv
module bcp_datapath
  import bcp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  ctlStrobe_t       ctl,
  input  logic [CNT_W-1:0] modVal,
  input  logic [CNT_W-1:0] activeCmp,
  input  logic [CNT_W-1:0] cmp1Val,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovfTick,
  output logic             ch0Out,
  output logic             ch1Out,
  output logic             matchFlag,
  output logic             ovfFlag
);
  localparam int N_CH = 2;

  logic [CNT_W-1:0] cmpSrc [N_CH];
  logic [N_CH-1:0]  hit;
  logic             ch0Next;

  assign cmpSrc[0] = activeCmp;
  assign cmpSrc[1] = cmp1Val;
  assign ovfTick   = cntEn && (cntVal == modVal);

  for (genvar i = 0; i < N_CH; i++) begin : gHit
    assign hit[i] = cntEn && (cntVal == cmpSrc[i]);
  end

  always_comb begin
    ch0Next = ch0Out;
    if (hit[0]) begin
      unique case (ctl.act)
        ACT_TOGGLE: ch0Next = ~ch0Out;
        ACT_CLEAR:  ch0Next = 1'b0;
        ACT_SET:    ch0Next = 1'b1;
        default:    ch0Next = ch0Out;
      endcase
    end
    if (ovfTick && ctl.togOvf) ch0Next = ~ch0Next;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal    <= '0;
      ch0Out    <= 1'b0;
      ch1Out    <= 1'b0;
      matchFlag <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      if (cntEn) cntVal <= ovfTick ? '0 : cntVal + 1'b1;
      ch0Out <= ch0Next;
      if (ctl.linked)  ch1Out <= 1'b0;
      else if (hit[1]) ch1Out <= ~ch1Out;
      if (hit[0])            matchFlag <= 1'b1;
      else if (ctl.clrMatch) matchFlag <= 1'b0;
      if (ovfTick)           ovfFlag <= 1'b1;
      else if (ctl.clrOvf)   ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/bufcmp_pair.sv
module bufcmp_pair
  import bcp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             cntEn,
  output logic             ch0Out,
  output logic             ch1Out,
  output logic             ch1Release,
  output logic             matchFlag,
  output logic             ovfFlag
);
  ctlStrobe_t       ctl;
  logic [CNT_W-1:0] modVal, activeCmp, cmp1Val, cntVal;
  logic             ovfTick;

  bcp_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ovfTick(ovfTick), .ctl(ctl), .modVal(modVal), .activeCmp(activeCmp),
    .cmp1Val(cmp1Val)
  );

  bcp_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .ctl(ctl), .modVal(modVal),
    .activeCmp(activeCmp), .cmp1Val(cmp1Val), .cntVal(cntVal),
    .ovfTick(ovfTick), .ch0Out(ch0Out), .ch1Out(ch1Out),
    .matchFlag(matchFlag), .ovfFlag(ovfFlag)
  );

  assign ch1Release = ctl.linked;
endmodule

// File: rtl/bcp_chk.sv
module bcp_chk
  import bcp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic             cntEn,
  input logic             ch0Out,
  input logic             ch1Out,
  input logic             ch1Release,
  input logic             matchFlag,
  input logic             ovfFlag,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] modVal
);
  logic ctlWr;
  assign ctlWr = wrEn && (wrAddr == ADDR_CTRL);

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && cntVal == modVal) |=> (cntVal == '0));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> ($stable(ch0Out) && $stable(cntVal)));

  // R4
  match_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !(ctlWr && wrData[BIT_CLRM])) |=> matchFlag);

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(ctlWr && wrData[BIT_CLRO])) |=> ovfFlag);

  // R9
  ch1_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ch1Release && $past(ch1Release)) |-> !ch1Out);

  // R5
  link_only_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWr |=> $stable(ch1Release));
endmodule

bind bufcmp_pair bcp_chk #(.CNT_W(CNT_W)) uChk (.*);

// File: tb/sim_bufcmp_pair.sv
module sim_bufcmp_pair;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic cntEn = 1'b0;
  logic ch0Out, ch1Out, ch1Release, matchFlag, ovfFlag;

  always #5 clk = ~clk;

  bufcmp_pair #(.CNT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntEn(cntEn), .ch0Out(ch0Out), .ch1Out(ch1Out), .ch1Release(ch1Release),
    .matchFlag(matchFlag), .ovfFlag(ovfFlag)
  );

  typedef struct {
    logic o0, o1, rel, mf, of;
    string req;
  } item_t;
  item_t q[$];

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string curReq = "R1";

  // reference state
  logic [W-1:0] mMod, mC0, mC1, mCnt;
  logic mLink, mTog, mSel, mLast, mO0, mO1, mMf, mOf;
  logic [1:0] mAct;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic act, input logic exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // monitor: compares each expected item against the pins
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(ch0Out == it.o0, it.req, "ch0Out", ch0Out, it.o0);
      chk(ch1Out == it.o1, it.req, "ch1Out", ch1Out, it.o1);
      chk(ch1Release == it.rel, it.req, "ch1Release", ch1Release, it.rel);
      chk(matchFlag == it.mf, it.req, "matchFlag", matchFlag, it.mf);
      chk(ovfFlag == it.of, it.req, "ovfFlag", ovfFlag, it.of);
    end
  end

  // driver: one clock cycle, with expected pins pushed after the edge
  task automatic step(input logic we, input logic [1:0] a, input logic [W-1:0] d,
                      input logic en);
    logic ovf, h0, h1, ctlWr, lastN, linkRise, nO0;
    logic [W-1:0] actC;
    item_t it;
    wrEn = we; wrAddr = a; wrData = d; cntEn = en;
    ctlWr = we && a == 2'd3;
    ovf  = en && mCnt == mMod;
    actC = (mLink && mSel) ? mC1 : mC0;
    h0 = en && mCnt == actC;
    h1 = en && mCnt == mC1;
    nO0 = mO0;
    if (h0) begin
      if (mAct == 2'b01) nO0 = ~mO0;
      else if (mAct == 2'b10) nO0 = 1'b0;
      else if (mAct == 2'b11) nO0 = 1'b1;
    end
    if (ovf && mTog) nO0 = ~nO0;
    lastN = (we && a == 2'd2) ? 1'b1 : (we && a == 2'd1) ? 1'b0 : mLast;
    linkRise = ctlWr && d[0] && !mLink;
    @(posedge clk);
    mO1 = mLink ? 1'b0 : (h1 ? ~mO1 : mO1);
    mO0 = nO0;
    mMf = h0 ? 1'b1 : (ctlWr && d[4]) ? 1'b0 : mMf;
    mOf = ovf ? 1'b1 : (ctlWr && d[5]) ? 1'b0 : mOf;
    if (linkRise || !mLink) mSel = 1'b0;
    else if (ovf) mSel = lastN;
    mLast = linkRise ? 1'b0 : lastN;
    if (en) mCnt = ovf ? '0 : mCnt + 1'b1;
    if (we && a == 2'd0) mMod = d;
    if (we && a == 2'd1) mC0 = d;
    if (we && a == 2'd2) mC1 = d;
    if (ctlWr) begin mLink = d[0]; mAct = d[2:1]; mTog = d[3]; end
    it.o0 = mO0; it.o1 = mO1; it.rel = mLink; it.mf = mMf; it.of = mOf;
    it.req = curReq;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic en);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, en);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    step(1'b1, a, d, 1'b1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mMod = '1; mC0 = '0; mC1 = '0; mCnt = '0;
    mLink = 0; mTog = 0; mSel = 0; mLast = 0; mO0 = 0; mO1 = 0;
    mMf = 0; mOf = 0; mAct = 2'b00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ch0Out == 0 && ch1Out == 0 && ch1Release == 0, "R1", "reset pins",
        ch0Out | ch1Out | ch1Release, 1'b0);
    chk(matchFlag == 0 && ovfFlag == 0, "R4", "reset flags", matchFlag | ovfFlag, 1'b0);

    // R1: short modulo, gaps in enable
    curReq = "R1";
    wr(2'd0, 8'd5);
    wr(2'd1, 8'd200);
    wr(2'd2, 8'd201);
    run(9, 1'b1);
    run(4, 1'b0);
    run(8, 1'b1);
    // R4: clear with the wrong bit, then the right one
    curReq = "R4";
    wr(2'd3, 8'h10);
    run(1, 1'b0);
    wr(2'd3, 8'h20);
    run(3, 1'b0);

    // R2: each action code
    curReq = "R2";
    wr(2'd1, 8'd2);
    wr(2'd3, 8'b0000_0110); run(12, 1'b1);
    wr(2'd3, 8'b0000_0100); run(12, 1'b1);
    wr(2'd3, 8'b0000_0010); run(14, 1'b1);
    wr(2'd3, 8'b0000_0000); run(8, 1'b1);
    curReq = "R4";
    wr(2'd3, 8'h30); run(2, 1'b0);

    // R3: overflow toggle, also coinciding with a match on the modulo value
    curReq = "R3";
    wr(2'd3, 8'b0000_1000); run(13, 1'b1);
    wr(2'd1, 8'd5);
    wr(2'd3, 8'b0000_1110); run(13, 1'b1);
    wr(2'd3, 8'b0000_1010); run(13, 1'b1);

    // R10: independent channels
    curReq = "R10";
    wr(2'd2, 8'd3);
    wr(2'd1, 8'd1);
    wr(2'd3, 8'b0000_0010); run(20, 1'b1);

    // R5 and R9: link with toggle action
    curReq = "R5";
    wr(2'd0, 8'd9);
    wr(2'd3, 8'b0000_0011); run(12, 1'b1);
    curReq = "R9";
    run(6, 1'b1);

    // R6: write channel 1 mid-period, no switch before overflow
    curReq = "R6";
    run(2, 1'b1);
    wr(2'd2, 8'd7);
    run(25, 1'b1);

    // R7: both written in one period, later write decides
    curReq = "R7";
    wr(2'd1, 8'd4);
    run(2, 1'b1);
    wr(2'd2, 8'd6);
    run(22, 1'b1);
    wr(2'd1, 8'd2);
    run(22, 1'b1);

    // R8: write to the register in control, and cancel a pending switch
    curReq = "R8";
    wr(2'd1, 8'd8);
    run(12, 1'b1);
    wr(2'd2, 8'd3);
    wr(2'd1, 8'd5);
    run(24, 1'b1);

    // R10: unlink returns to independent operation
    curReq = "R10";
    wr(2'd2, 8'd6);
    wr(2'd3, 8'b0000_0010);
    run(24, 1'b1);

    run(2, 1'b0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule